// File: doc/BRIEF.md
# Selector privilege-level adjust unit

This unit executes the selector privilege-raise operation of an integer pipeline. It takes two 16-bit segment selectors: a destination, which is the selector under adjustment, and a source, which must come from a register. The low two bits of a selector are its requestor privilege field. When the destination's field is numerically below the source's field, the destination's field is replaced by the source's field and the zero flag result is 1. Otherwise the destination stays as it is and the zero flag result is 0. The upper fourteen bits, which hold the index and the table indicator, are never touched. The zero flag is the only status flag the operation writes.

The unit also decides whether the operation is legal in the current operating mode. It is legal only in protected legacy mode and in compatibility mode. Real mode and virtual-8086 mode raise invalid opcode. In 64-bit mode the same opcode belongs to a different instruction, and the unit reports that condition separately. Whenever it reports an exception, it asserts no write enable.

The result, the flag, the write enables and the exception code are all registered. They appear one cycle after the input strobe, together with a one-cycle done pulse.

Top module: `sel_rpl_adjust`

## Requirements
- R1: While reset is low and after reset, every output is 0 until the first strobe.
- R2: In mode code 2 (protected legacy) or 3 (compatibility), if dst_sel[1:0] < src_sel[1:0], then out_result[1:0] equals src_sel[1:0], out_zf is 1, and both out_result_we and out_zf_we are 1.
- R3: In mode code 2 or 3, if dst_sel[1:0] >= src_sel[1:0], then out_result equals dst_sel, out_zf is 0, and both write enables are 1.
- R4: In every mode and every case, out_result[15:2] equals dst_sel[15:2].
- R5: Mode code 0 (real), mode code 1 (virtual-8086) and the unused codes 5 to 7 give out_exc = 1 (invalid opcode). In that case out_result equals dst_sel, out_zf is 0 and both write enables are 0.
- R6: Mode code 4 (64-bit) gives out_exc = 2 (opcode belongs to another instruction), with out_result equal to dst_sel, out_zf 0 and both write enables 0. out_exc = 0 means no exception.
- R7: out_done is high in exactly the cycle after each cycle in which in_valid was high, including back-to-back strobes, and it is low otherwise.
- R8: Both write enables are low in every cycle in which out_done is low, and out_result, out_zf and out_exc hold their values until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| dst_sel | input | 16 | Destination selector |
| src_sel | input | 16 | Source selector (register operand) |
| cpu_mode | input | 3 | 0 real, 1 virtual-8086, 2 protected legacy, 3 compatibility, 4 64-bit |
| out_done | output | 1 | One-cycle pulse, result valid |
| out_result | output | 16 | Adjusted destination selector |
| out_result_we | output | 1 | Write enable for the destination |
| out_zf | output | 1 | Zero flag value |
| out_zf_we | output | 1 | Zero flag write enable |
| out_exc | output | 2 | 0 none, 1 invalid opcode, 2 other instruction |

## Verification
On every cycle, the assertions check the following: the done pulse follows the strobe and appears only then; no write enable is raised when an exception is reported or outside a done pulse; the upper selector bits pass through; an enabled write never lowers the privilege field below the source's field; and the flag is set exactly when the field changed. Only the bench's sweep can show the rest. It confirms that every combination of mode code and the two privilege fields maps to the right exception code and result value. It also shows the reset state and that results hold between strobes.

// File: rtl/sel_rpl_adjust.sv
module sel_rpl_adjust #(
  parameter int SEL_W  = 16,
  parameter int RPL_W  = 2,
  parameter int MODE_W = 3,
  parameter int EXC_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SEL_W-1:0]  dst_sel,
  input  logic [SEL_W-1:0]  src_sel,
  input  logic [MODE_W-1:0] cpu_mode,
  output logic              out_done,
  output logic [SEL_W-1:0]  out_result,
  output logic              out_result_we,
  output logic              out_zf,
  output logic              out_zf_we,
  output logic [EXC_W-1:0]  out_exc
);

  localparam logic [MODE_W-1:0] M_PROT   = MODE_W'(2);
  localparam logic [MODE_W-1:0] M_COMPAT = MODE_W'(3);
  localparam logic [MODE_W-1:0] M_LONG   = MODE_W'(4);
  localparam logic [EXC_W-1:0]  E_NONE   = EXC_W'(0);
  localparam logic [EXC_W-1:0]  E_UD     = EXC_W'(1);
  localparam logic [EXC_W-1:0]  E_ALT    = EXC_W'(2);
  localparam int                HI_W     = SEL_W - RPL_W;

  logic [RPL_W-1:0] d_rpl, s_rpl, new_rpl;
  logic             legal, raise;
  logic [EXC_W-1:0] exc_nxt;

  assign d_rpl   = dst_sel[RPL_W-1:0];
  assign s_rpl   = src_sel[RPL_W-1:0];
  assign legal   = (cpu_mode == M_PROT) || (cpu_mode == M_COMPAT);
  assign raise   = legal && (d_rpl < s_rpl);
  assign new_rpl = raise ? s_rpl : d_rpl;
  assign exc_nxt = legal ? E_NONE : ((cpu_mode == M_LONG) ? E_ALT : E_UD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_done      <= 1'b0;
      out_result    <= '0;
      out_result_we <= 1'b0;
      out_zf        <= 1'b0;
      out_zf_we     <= 1'b0;
      out_exc       <= E_NONE;
    end else begin
      out_done      <= in_valid;
      out_result_we <= in_valid && legal;
      out_zf_we     <= in_valid && legal;
      if (in_valid) begin
        out_result <= {dst_sel[SEL_W-1:RPL_W], new_rpl};
        out_zf     <= raise;
        out_exc    <= exc_nxt;
      end
    end
  end

  // R7
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_done);
  // R7
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_done);
  // R5 R6
  exc_blocks_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_exc != E_NONE) |-> (!out_result_we && !out_zf_we));
  // R8
  we_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_done |-> (!out_result_we && !out_zf_we));
  // R4
  upper_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_result[SEL_W-1:RPL_W] == $past(dst_sel[SEL_W-1:RPL_W])));
  // R2 R3
  never_below_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (!out_result_we || (out_result[RPL_W-1:0] >= $past(s_rpl))));
  // R2 R3
  zf_marks_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_zf == (out_result[RPL_W-1:0] != $past(d_rpl))));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_result) && $stable(out_zf) && $stable(out_exc)));

  initial assert (HI_W > 0) else $error("selector narrower than privilege field");

endmodule

// File: tb/sim_sel_rpl_adjust.sv
`timescale 1ns/1ps
module sim_sel_rpl_adjust;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] dst_sel = '0, src_sel = '0;
  logic [2:0]  cpu_mode = '0;
  logic        out_done, out_result_we, out_zf, out_zf_we;
  logic [15:0] out_result;
  logic [1:0]  out_exc;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sel_rpl_adjust u0 (.clk, .rst_n, .in_valid, .dst_sel, .src_sel, .cpu_mode,
    .out_done, .out_result, .out_result_we, .out_zf, .out_zf_we, .out_exc);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic verify(input logic [15:0] d, input logic [15:0] s, input logic [2:0] m);
    bit          lg = (m == 3'd2) || (m == 3'd3);
    bit          rs = lg && (d[1:0] < s[1:0]);
    logic [1:0]  ex = lg ? 2'd0 : ((m == 3'd4) ? 2'd2 : 2'd1);
    logic [15:0] r  = {d[15:2], rs ? s[1:0] : d[1:0]};
    string       tg = !lg ? ((m == 3'd4) ? "R6" : "R5") : (rs ? "R2" : "R3");
    chk(out_done == 1'b1, "R7 done", out_done, 1);
    chk(out_exc == ex, {tg, " exc"}, out_exc, ex);
    chk(out_result == r, {tg, " result"}, out_result, r);
    chk(out_result[15:2] == d[15:2], "R4 upper", out_result[15:2], d[15:2]);
    chk(out_zf == rs, {tg, " zf"}, out_zf, rs);
    chk(out_result_we == lg && out_zf_we == lg, {tg, " we"},
        {out_result_we, out_zf_we}, {lg, lg});
  endtask

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, s, prev_r;
    logic [2:0]  pm;
    repeat (3) @(negedge clk);
    chk({out_done, out_result, out_result_we, out_zf, out_zf_we, out_exc} == '0,
        "R1 reset in", out_result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({out_done, out_result, out_result_we, out_zf, out_zf_we, out_exc} == '0,
        "R1 reset out", out_result, 0);

    for (int m = 0; m < 8; m++)
      for (int dr = 0; dr < 4; dr++)
        for (int sr = 0; sr < 4; sr++) begin
          d = {14'((m * 16 + dr * 4 + sr) * 613 + 77), 2'(dr)};
          s = {14'((m + dr + sr) * 2749 + 3), 2'(sr)};
          dst_sel = d; src_sel = s; cpu_mode = 3'(m); in_valid = 1'b1;
          @(negedge clk);
          in_valid = 1'b0;
          dst_sel = ~d; src_sel = ~s; cpu_mode = 3'd2;
          verify(d, s, 3'(m));
          prev_r = out_result; pm = out_exc;
          @(negedge clk);
          chk(out_done == 1'b0, "R7 idle done", out_done, 0);
          chk(!out_result_we && !out_zf_we, "R8 idle we", {out_result_we, out_zf_we}, 0);
          chk(out_result == prev_r && out_exc == pm, "R8 hold", out_result, prev_r);
        end

    for (int k = 0; k < 12; k++) begin
      d = 16'(16'hA5A4 + k * 16'h1111) & 16'hFFFC | 16'(k % 4);
      s = 16'(k * 16'h0707) & 16'hFFFC | 16'((k / 4) % 4);
      dst_sel = d; src_sel = s; cpu_mode = 3'(k % 5); in_valid = 1'b1;
      @(negedge clk);
      verify(d, s, 3'(k % 5));
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_done == 1'b0, "R7 after burst", out_done, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule